// File: doc/BRIEF.md
# Dual-Output Serial Flash Read Master

This block is the host side of a fast read from a serial NOR flash. A client hands it a 24-bit start address and a byte count. The master lowers chip select and runs a divided serial clock that idles low. On the shared data line it sends the read opcode 0x3B, then the address, then eight dummy clocks. After that it stops driving the line and samples two bits per clock. The flash's main output line gives the high bit of each pair and the shared line gives the low bit. Every four pairs make one byte, which is presented on a valid/ready stream.

The flash itself wraps reads past its top address back to zero, so the master sends the start address unchanged and only counts bytes. If the consumer stalls, the master holds the serial clock low until the pending byte is taken, so no data is lost. After the last byte the master raises chip select and pulses `done` in the same cycle, then keeps the flash deselected for a minimum time. An `abort` input ends a transfer at any point, including part-way through a byte.

Top module: `dual_read_master`

## Requirements
- R1: Out of reset and whenever chip select is high, `sck` is low, `dq0_oe` is low, `out_valid` and `done` are low, and `req_ready` is high while idle.
- R2: After a request is accepted, the first 40 rising edges of `sck` carry 0x3B, then `req_addr[23:0]`, then 8 dummy bits, all MSB first on `dq0_o`. `dq0_oe` is high at each of those edges.
- R3: `dq0_oe` drops at the falling edge that follows the 40th rising edge. It stays low for the rest of the transfer.
- R4: Each later rising edge samples one bit pair: `dq1_i` is the more significant bit and `dq0_i` the less significant. The first pair of a byte is bits 7 and 6, and a byte is complete every four edges.
- R5: Exactly `req_len` bytes are delivered (`req_len` ≥ 1). The address is never altered, so a flash that wraps at its top address yields a continuous stream.
- R6: Every high phase of `sck` lasts exactly `sck_div` system clocks, where `sck_div` is sampled when the request is accepted. Low phases last at least that long.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` is held and `sck` makes no rising edge.
- R8: `done` is a one-cycle pulse in the first cycle chip select is high after a completed transfer. Chip select then stays high for at least 2 system clocks before it falls again.
- R9: Asserting `abort` during a transfer raises chip select, forces `sck` low and releases `dq0_oe` on the next clock. The partial byte is discarded and `done` does not pulse.
- R10: A request is taken when `req_valid` and `req_ready` are both high. `req_ready` is low from then until the master returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_div | input | DIV_W | Serial clock half period in system clocks, nonzero |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Master idle and able to take a request |
| req_addr | input | 24 | First flash byte address |
| req_len | input | LEN_W | Number of bytes to read, nonzero |
| abort | input | 1 | End the current transfer at once |
| done | output | 1 | One-cycle pulse when a transfer completes |
| cs_n | output | 1 | Flash chip select, active low |
| sck | output | 1 | Serial clock to the flash |
| dq0_o | output | 1 | Shared data line, output value |
| dq0_oe | output | 1 | Shared data line, output enable |
| dq0_i | input | 1 | Shared data line, input (low bit of each pair) |
| dq1_i | input | 1 | Flash main output line (high bit of each pair) |
| out_valid | output | 1 | Assembled byte available |
| out_data | output | 8 | Assembled byte |
| out_ready | input | 1 | Consumer accepts the byte |

## Verification
The assertions assume that every request carries a nonzero byte count and a nonzero divider. They also assume that `dq0_i` and `dq1_i` are already synchronous to `clk` and stable from one serial falling edge to the next. The bench meets these assumptions with a flash model that runs on the system clock. The model only changes its output lines in the cycle after it sees `sck` fall, and every table row and directed case uses lengths and dividers of one or more. The model also captures the command bits, checks for drive contention on the shared line, and serves data from a computed memory that wraps at its top address.

// File: rtl/dr_pkg.sv
package dr_pkg;
  localparam int unsigned CMD_BITS   = 40;
  localparam logic [7:0]  RD_DUAL_OP = 8'h3B;
  localparam int unsigned PAIRS_PER_BYTE = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_TAIL,
    ST_DESEL
  } dr_state_e;
endpackage

// File: rtl/dr_rst_sync.sv
module dr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/dr_sck_gen.sv
module dr_sck_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             sck,
  output logic             rise,
  output logic             fall
);
  logic [DIV_W-1:0] cnt_q, cnt_n;
  logic             sck_n;
  logic             tick;

  always_comb begin
    tick  = en && !clr && (cnt_q == div - 1'b1);
    rise  = tick && !sck;
    fall  = tick &&  sck;
    cnt_n = cnt_q;
    sck_n = sck;
    if (clr) begin
      cnt_n = '0;
      sck_n = 1'b0;
    end else if (!en) begin
      cnt_n = '0;
    end else if (tick) begin
      cnt_n = '0;
      sck_n = !sck;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      sck   <= sck_n;
    end
  end

  AST_SCK_CLR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !sck);  // R9
  AST_SCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(sck));  // R7
endmodule

// File: rtl/dr_cmd_shift.sv
module dr_cmd_shift
  import dr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [23:0] addr,
  input  logic        clr,
  input  logic        rise,
  input  logic        fall,
  output logic        dq0_o,
  output logic        dq0_oe,
  output logic        last_rise
);
  localparam int CNT_W = $clog2(CMD_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(CMD_BITS);
  localparam logic [CNT_W-1:0] CNT_LST = CNT_W'(CMD_BITS - 1);

  logic [CMD_BITS-1:0] sr_q, sr_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic                oe_q, oe_n;
  logic                active;

  assign active    = oe_q && (cnt_q != CNT_END);
  assign last_rise = rise && active && (cnt_q == CNT_LST);
  assign dq0_o     = sr_q[CMD_BITS-1];
  assign dq0_oe    = oe_q;

  always_comb begin
    sr_n  = sr_q;
    cnt_n = cnt_q;
    oe_n  = oe_q;
    if (load) begin
      sr_n  = {RD_DUAL_OP, addr, 8'h00};
      cnt_n = '0;
      oe_n  = 1'b1;
    end else if (clr) begin
      cnt_n = '0;
      oe_n  = 1'b0;
    end else begin
      if (rise && active) cnt_n = cnt_q + 1'b1;
      if (fall && oe_q) begin
        if (cnt_q == CNT_END) oe_n = 1'b0;
        else                  sr_n = {sr_q[CMD_BITS-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      sr_q  <= sr_n;
      cnt_q <= cnt_n;
      oe_q  <= oe_n;
    end
  end

  AST_DQ_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !load) |=> $stable(dq0_o));  // R2
endmodule

// File: rtl/dr_byte_asm.sv
module dr_byte_asm
  import dr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       sample,
  input  logic       hi_bit,
  input  logic       lo_bit,
  input  logic       out_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       byte_done
);
  localparam int PW = $clog2(PAIRS_PER_BYTE);
  localparam logic [PW-1:0] PAIR_LAST = PW'(PAIRS_PER_BYTE - 1);

  logic [5:0]    sh_q, sh_n;
  logic [PW-1:0] pair_q, pair_n;
  logic          valid_n;
  logic [7:0]    data_n;

  assign byte_done = sample && (pair_q == PAIR_LAST);

  always_comb begin
    sh_n    = sh_q;
    pair_n  = pair_q;
    valid_n = out_valid;
    data_n  = out_data;
    if (clr) begin
      pair_n = '0;
    end else if (sample) begin
      sh_n   = {sh_q[3:0], hi_bit, lo_bit};
      pair_n = pair_q + 1'b1;
    end
    if (byte_done && !clr) begin
      valid_n = 1'b1;
      data_n  = {sh_q, hi_bit, lo_bit};
    end else if (out_ready) begin
      valid_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q      <= '0;
      pair_q    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      sh_q      <= sh_n;
      pair_q    <= pair_n;
      out_valid <= valid_n;
      out_data  <= data_n;
    end
  end

  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));  // R7
endmodule

// File: rtl/dual_read_master.sv
module dual_read_master
  import dr_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int LEN_W     = 16,
  parameter int DESEL_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] sck_div,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             abort,
  output logic             done,
  output logic             cs_n,
  output logic             sck,
  output logic             dq0_o,
  output logic             dq0_oe,
  input  logic             dq0_i,
  input  logic             dq1_i,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready
);
  localparam int DW = $clog2(DESEL_CYC + 1);
  localparam logic [DW-1:0] DESEL_LAST = DW'(DESEL_CYC - 1);

  logic             rst_q_n;
  dr_state_e        state_q, state_n;
  logic [LEN_W-1:0] left_q, left_n;
  logic [DIV_W-1:0] div_q, div_n;
  logic [DW-1:0]    dsl_q, dsl_n;
  logic             cs_n_n, done_n;
  logic             accept, in_xfer, kill, stall, gen_en, sample;
  logic             rise, fall, last_rise, byte_done;

  dr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_xfer   = (state_q == ST_CMD) || (state_q == ST_DATA) || (state_q == ST_TAIL);
  assign kill      = abort && in_xfer;
  assign stall     = !sck && out_valid && !out_ready;
  assign gen_en    = (((state_q == ST_CMD) || (state_q == ST_DATA)) && !stall)
                     || (state_q == ST_TAIL);
  assign sample    = rise && (state_q == ST_DATA);

  dr_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk   (clk),
    .rst_n (rst_q_n),
    .clr   (kill),
    .en    (gen_en),
    .div   (div_q),
    .sck   (sck),
    .rise  (rise),
    .fall  (fall)
  );

  dr_cmd_shift u_cmd (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .load      (accept),
    .addr      (req_addr),
    .clr       (kill),
    .rise      (rise),
    .fall      (fall),
    .dq0_o     (dq0_o),
    .dq0_oe    (dq0_oe),
    .last_rise (last_rise)
  );

  dr_byte_asm u_asm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .clr       (accept || kill),
    .sample    (sample),
    .hi_bit    (dq1_i),
    .lo_bit    (dq0_i),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .byte_done (byte_done)
  );

  always_comb begin
    state_n = state_q;
    left_n  = left_q;
    div_n   = div_q;
    dsl_n   = '0;
    done_n  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_n = ST_CMD;
          left_n  = req_len;
          div_n   = sck_div;
        end
      end
      ST_CMD: begin
        if (kill)           state_n = ST_DESEL;
        else if (last_rise) state_n = ST_DATA;
      end
      ST_DATA: begin
        if (kill) begin
          state_n = ST_DESEL;
        end else if (byte_done) begin
          left_n = left_q - 1'b1;
          if (left_q == LEN_W'(1)) state_n = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (kill) begin
          state_n = ST_DESEL;
        end else if (fall) begin
          state_n = ST_DESEL;
          done_n  = 1'b1;
        end
      end
      ST_DESEL: begin
        dsl_n = dsl_q + 1'b1;
        if (dsl_q == DESEL_LAST) begin
          state_n = ST_IDLE;
          dsl_n   = '0;
        end
      end
      default: state_n = ST_IDLE;
    endcase
    cs_n_n = !((state_n == ST_CMD) || (state_n == ST_DATA) || (state_n == ST_TAIL));
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      left_q  <= '0;
      div_q   <= '0;
      dsl_q   <= '0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      state_q <= state_n;
      left_q  <= left_n;
      div_q   <= div_n;
      dsl_q   <= dsl_n;
      cs_n    <= cs_n_n;
      done    <= done_n;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_q_n)
    cs_n |-> (!sck && !dq0_oe));  // R1
  AST_REQ_LEGAL: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |-> ((req_len != '0) && (sck_div != '0)));  // R5
  AST_NO_RISE_IN_STALL: assert property (@(posedge clk) disable iff (!rst_q_n)
    (out_valid && !out_ready && !sck) |=> !sck);  // R7
  AST_DONE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |-> cs_n);  // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    done |=> !done);  // R8
  AST_DESEL_MIN: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(cs_n) |-> ($past(cs_n, 1) && $past(cs_n, 2)));  // R8
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_q_n)
    (abort && !cs_n) |=> (cs_n && !sck && !dq0_oe && !done));  // R9
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && req_ready) |=> !req_ready);  // R10
endmodule

// File: tb/dual_read_master_tb.sv
module dual_read_master_tb;
  localparam int DIV_W = 8;
  localparam int LEN_W = 16;
  localparam logic [23:0] MEM_MASK = 24'h1FFFFF;
  localparam int NVEC = 5;
  // {addr[23:0], len[15:0], div[7:0], ready_mode[7:0]}
  localparam logic [55:0] VEC [NVEC] = '{
    {24'h000010, 16'd4, 8'd1, 8'd0},
    {24'h123456, 16'd7, 8'd3, 8'd1},
    {24'h1FFFFE, 16'd5, 8'd2, 8'd0},
    {24'hABCDEF, 16'd3, 8'd1, 8'd2},
    {24'h000000, 16'd1, 8'd4, 8'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] sck_div;
  logic             req_valid, req_ready;
  logic [23:0]      req_addr;
  logic [LEN_W-1:0] req_len;
  logic             abort, done, cs_n, sck, dq0_o, dq0_oe;
  logic             m_lo, m_hi;
  logic             out_valid, out_ready;
  logic [7:0]       out_data;

  always #2 clk = ~clk;

  dual_read_master #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck_div(sck_div), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .abort(abort), .done(done), .cs_n(cs_n), .sck(sck), .dq0_o(dq0_o),
    .dq0_oe(dq0_oe), .dq0_i(m_lo), .dq1_i(m_hi), .out_valid(out_valid),
    .out_data(out_data), .out_ready(out_ready)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    logic [23:0] m;
    m = a & MEM_MASK;
    return m[7:0] ^ {m[12:8], 3'b101} ^ m[20:13];
  endfunction

  int n_chk = 0, n_err = 0;
  int m_chk = 0, m_err = 0;
  logic [23:0] exp_addr = '0;
  int cur_div = 1;
  bit chk_div = 1'b1;

  // flash model and port monitors
  int rises = 0, hi_run = 0, cs_run = 0, done_cnt = 0, p, bi;
  logic [39:0] cap = '0, capn;
  logic [7:0] b;
  logic drv = 1'b0, sck_prev = 1'b0, cs_prev = 1'b1, done_prev = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      rises = 0; drv = 1'b0; m_hi = 1'b0; m_lo = 1'b0;
      sck_prev = 1'b0; cs_prev = 1'b1; done_prev = 1'b0; hi_run = 0; cs_run = 0;
    end else begin
      if (cs_n && sck) begin
        m_chk++; m_err++;
        $display("FAIL R1: sck=%0b with cs_n high, expected 0", sck);
      end
      if (cs_n) begin
        rises = 0; drv = 1'b0;
      end else begin
        if (sck && !sck_prev) begin
          if (rises < 40) begin
            m_chk++;
            if (!dq0_oe) begin
              m_err++; $display("FAIL R2: dq0_oe=0 at command edge %0d, expected 1", rises);
            end
            capn = {cap[38:0], dq0_o};
            cap = capn;
            if (rises == 39) begin
              m_chk++;
              if (capn[39:32] != 8'h3B || capn[31:8] != exp_addr) begin
                m_err++;
                $display("FAIL R2: opcode/addr %h/%h, expected 3b/%h",
                         capn[39:32], capn[31:8], exp_addr);
              end
            end
          end
          rises++;
        end else if (!sck && sck_prev && rises >= 40) begin
          drv = 1'b1;
          p  = (rises - 40) % 4;
          bi = (rises - 40) / 4;
          b  = mem_byte(exp_addr + 24'(bi));
          m_hi = b[7-2*p];
          m_lo = b[6-2*p];
        end
        if (drv) begin
          m_chk++;
          if (dq0_oe) begin
            m_err++; $display("FAIL R3: dq0_oe=1 while flash drives, expected 0");
          end
        end
      end
      if (sck) hi_run++;
      else if (sck_prev) begin
        if (chk_div) begin
          m_chk++;
          if (hi_run != cur_div) begin
            m_err++; $display("FAIL R6: sck high for %0d clocks, expected %0d", hi_run, cur_div);
          end
        end
        hi_run = 0;
      end
      if (cs_n) cs_run++;
      else if (cs_prev) begin
        m_chk++;
        if (cs_run < 2) begin
          m_err++; $display("FAIL R8: deselect %0d clocks, expected >=2", cs_run);
        end
        cs_run = 0;
      end
      if (done) begin
        done_cnt++;
        m_chk++;
        if (!cs_n || done_prev) begin
          m_err++; $display("FAIL R8: done with cs_n=%0b prev=%0b, expected 1/0", cs_n, done_prev);
        end
      end
      sck_prev = sck; cs_prev = cs_n; done_prev = done;
    end
  end

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic start_req(input logic [23:0] a, input logic [15:0] n, input logic [7:0] d);
    exp_addr = a;
    cur_div  = int'(d);
    for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
    req_addr = a; req_len = n; sck_div = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, $sformatf("R10: req_ready=%0b after accept, expected 0", req_ready));
  endtask

  task automatic collect(input int n, input int mode);
    int got = 0;
    int dn0 = done_cnt;
    for (int cyc = 0; cyc < 20000 && !(got == n && done_cnt != dn0); cyc++) begin
      out_ready = (mode == 0) ? 1'b1 : (mode == 1) ? cyc[0] : ((cyc % 5) == 0);
      if (out_valid && out_ready) begin
        check(out_data == mem_byte(exp_addr + 24'(got)),
              $sformatf("R4: byte %0d = %h, expected %h", got, out_data,
                        mem_byte(exp_addr + 24'(got))));
        got++;
      end
      @(negedge clk);
    end
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(got == n && !out_valid,
          $sformatf("R5: %0d bytes valid=%0b, expected %0d bytes valid=0", got, out_valid, n));
    check(done_cnt - dn0 == 1,
          $sformatf("R8: %0d done pulses, expected 1", done_cnt - dn0));
  endtask

  initial begin
    int wd_cnt = 0;
    while (wd_cnt < 150000) begin
      @(posedge clk);
      wd_cnt++;
    end
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk + 1, n_err + m_err + 1);
    $finish;
  end

  initial begin
    logic [7:0] d0;
    int dn0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = 16'd1;
    sck_div = 8'd1; abort = 1'b0; out_ready = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state, R1 and R10
    check(cs_n && !sck && !dq0_oe && !out_valid && !done,
          $sformatf("R1: cs_n=%0b sck=%0b oe=%0b v=%0b done=%0b, expected 1/0/0/0/0",
                    cs_n, sck, dq0_oe, out_valid, done));
    check(req_ready, $sformatf("R10: req_ready=%0b after reset, expected 1", req_ready));

    // table-driven transfers: R2..R6, R8 (row 2 crosses the top address, R5)
    for (int v = 0; v < NVEC; v++) begin
      start_req(VEC[v][55:32], VEC[v][31:16], VEC[v][15:8]);
      collect(int'(VEC[v][31:16]), int'(VEC[v][7:0]));
    end

    // R7: consumer stalls after the first byte
    out_ready = 1'b0;
    start_req(24'h000200, 16'd3, 8'd1);
    for (int i = 0; i < 2000 && !out_valid; i++) @(negedge clk);
    d0 = out_data;
    repeat (40) @(negedge clk);
    check(out_valid && out_data == d0 && rises == 44,
          $sformatf("R7: valid=%0b data=%h rises=%0d, expected 1/%h/44", out_valid, out_data, rises, d0));
    check(d0 == mem_byte(24'h000200),
          $sformatf("R4: stalled byte %h, expected %h", d0, mem_byte(24'h000200)));
    collect(3, 0);

    // R9: abort part-way through the first data byte
    chk_div = 1'b0;
    dn0 = done_cnt;
    start_req(24'h054321, 16'd10, 8'd2);
    for (int i = 0; i < 2000 && rises < 42; i++) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    check(cs_n && !sck && !dq0_oe,
          $sformatf("R9: cs_n=%0b sck=%0b oe=%0b after abort, expected 1/0/0", cs_n, sck, dq0_oe));
    repeat (20) @(negedge clk);
    check(done_cnt == dn0 && !out_valid,
          $sformatf("R9: done pulses=%0d valid=%0b after abort, expected 0/0", done_cnt - dn0, out_valid));
    check(req_ready, $sformatf("R10: req_ready=%0b after abort, expected 1", req_ready));
    chk_div = 1'b1;

    // recovery after abort
    start_req(24'h0FFFFF, 16'd2, 8'd1);
    collect(2, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk + m_chk, n_err + m_err);
    $finish;
  end
endmodule